// File: doc/BRIEF.md
# Seconds Counter Clock Unit

This block is the clock-function layer of a real-time-clock slave on a single-wire bus. It keeps a 32-bit count of seconds, a control byte and a five-byte transfer buffer. The control byte holds the oscillator enable and four user flags. A 15-bit prescaler divides a 32.768 kHz enable strobe into the one-second advance. The prescaler and the counter run only while the oscillator enable is set, and the enable is clear at power-up.

The block works at byte level. A bit layer below it delivers received bytes and accepts transmit bytes. A ROM-addressing layer tells it when the function phase of a transaction begins. The first byte of that phase selects a read of the clock (66h) or a write of the clock (99h).

A read freezes the counter and the control byte into the buffer on the command byte. The buffer is then streamed in a loop. A write applies the control byte at once. The four time bytes are held in the buffer and move into the counter at the next bus reset.

Top module: `rtc_clock_unit`

## Requirements
- R1: After power-on reset `tx_valid` is 0. A read then returns control byte 00h and time 0.
- R2: While the oscillator is enabled, the counter advances by exactly one every 2^PRESCALE_W `tick_32k` strobes, and wraps from FFFFFFFFh to 0.
- R3: While the oscillator is disabled, `tick_32k` strobes change neither the counter nor the prescaler phase.
- R4: The control byte reads back as bits 7:4 = user flags, bit 3 = bit 2 = oscillator enable, and bits 1:0 = 0.
- R5: On a control-byte write, bit 3 alone sets the oscillator enable; bit 2 is ignored.
- R6: Read command 66h copies the control byte and the counter into the buffer when the command byte is received. It then presents the control byte, followed by time bytes 0 to 3, least significant first. Counter changes after the command do not alter the streamed data.
- R7: After the fifth byte of a read, the same five bytes repeat in the same order for as long as reading continues.
- R8: Write command 99h takes the control byte as its first data byte. The new oscillator state acts immediately, before any bus reset.
- R9: The four time bytes after the control byte, least significant first, are loaded into the counter on the next `bus_rst`. Any prescaler phase is kept.
- R10: A write transaction that ends before its first time byte leaves the counter unchanged at the next `bus_rst`.
- R11: The following are all ignored: bytes received before `rom_grant`, a command byte other than 66h or 99h together with every later byte of that transaction, and bytes received during a read.
- R12: `bus_rst` ends a read at any point, and `tx_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at 32.768 kHz |
| bus_rst | input | 1 | One-cycle strobe: reset pulse seen on the bus |
| rom_grant | input | 1 | One-cycle strobe: ROM layer opens the function phase |
| rx_stb | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| tx_taken | input | 1 | Bit layer consumed the current transmit byte |
| tx_valid | output | 1 | Transmit byte available (read in progress) |
| tx_data | output | 8 | Current transmit byte |

## Verification
A wrong prescaler or counter state shows up on the next read as a time value that differs from the arithmetic count of strobes. The mismatch is visible one second-boundary after the fault at the latest. A wrong buffer or index state appears in the very next streamed byte, or on the sixth byte when the read loops back. A lost or spurious pending-load flag shows up only after the following bus reset, in the time returned by the next read. A stuck state machine shows at once as `tx_valid` present or missing in the cycle after a command or a reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TIME_BYTES = 4;
  localparam int BUF_BYTES  = TIME_BYTES + 1;
  localparam int SEC_W      = 8 * TIME_BYTES;
  localparam logic [7:0] CMD_RD_CLOCK = 8'h66;
  localparam logic [7:0] CMD_WR_CLOCK = 8'h99;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } fn_state_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_in,
  output logic sec_tick
);
  logic [PRESCALE_W-1:0] phase_q, phase_d;
  logic                  phase_en;

  assign phase_en = run && tick_in;
  assign sec_tick = phase_en && (&phase_q);

  always_comb begin
    phase_d = phase_q;
    if (phase_en) phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R3: a stopped oscillator freezes the phase
  assert_presc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(phase_q));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] count
);
  logic [SEC_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (load)     count_d = load_val;
    else if (adv) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> count_q == $past(count_q) + 1'b1);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(count_q));
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(load_val));
endmodule

// File: rtl/rtc_fn_ctrl.sv
module rtc_fn_ctrl
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             rom_grant,
  input  logic             rx_stb,
  input  logic [7:0]       rx_data,
  input  logic             tx_taken,
  input  logic [SEC_W-1:0] count,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             osc_on,
  output logic             load,
  output logic [SEC_W-1:0] load_val
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUF_BYTES - 1);

  fn_state_t                    state_q, state_d;
  logic [IDX_W-1:0]             idx_q, idx_d;
  logic [BUF_BYTES-1:0][7:0]    buf_q, buf_d;
  logic                         osc_q, osc_d;
  logic [3:0]                   flags_q, flags_d;
  logic                         pend_q, pend_d;
  logic [7:0]                   ctrl_byte;

  assign ctrl_byte = {flags_q, osc_q, osc_q, 2'b00};

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    buf_d   = buf_q;
    osc_d   = osc_q;
    flags_d = flags_q;
    pend_d  = pend_q;
    if (bus_rst) begin
      state_d = ST_IDLE;
      idx_d   = '0;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rom_grant) state_d = ST_CMD;
        ST_CMD: if (rx_stb) begin
          idx_d = '0;
          if (rx_data == CMD_RD_CLOCK) begin
            state_d  = ST_READ;
            buf_d[0] = ctrl_byte;
            for (int b = 0; b < TIME_BYTES; b++)
              buf_d[b+1] = count[8*b +: 8];
          end else if (rx_data == CMD_WR_CLOCK) begin
            state_d = ST_WRITE;
          end else begin
            state_d = ST_DONE;
          end
        end
        ST_READ: if (tx_taken)
          idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        ST_WRITE: if (rx_stb) begin
          if (idx_q == '0) begin
            osc_d    = rx_data[3];
            flags_d  = rx_data[7:4];
            buf_d[0] = {rx_data[7:4], rx_data[3], rx_data[3], 2'b00};
          end else begin
            buf_d[idx_q] = rx_data;
            pend_d       = 1'b1;
          end
          if (idx_q == IDX_LAST) state_d = ST_DONE;
          else                   idx_d   = idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      buf_q   <= '0;
      osc_q   <= 1'b0;
      flags_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      buf_q   <= buf_d;
      osc_q   <= osc_d;
      flags_q <= flags_d;
      pend_q  <= pend_d;
    end
  end

  assign tx_valid = (state_q == ST_READ);
  assign tx_data  = buf_q[idx_q];
  assign osc_on   = osc_q;
  assign load     = bus_rst && pend_q;
  always_comb
    for (int b = 0; b < TIME_BYTES; b++)
      load_val[8*b +: 8] = buf_q[b+1];

  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !tx_valid);
  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && !bus_rst) |=> $stable(buf_q));
  assert_ctrl_fmt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && idx_q == '0) |-> (tx_data[1:0] == 2'b00 && tx_data[3] == tx_data[2]));
  assert_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_taken && idx_q == IDX_LAST && !bus_rst) |=> (tx_valid && idx_q == '0));
endmodule

// File: rtl/rtc_clock_unit.sv
module rtc_clock_unit
  import rtc_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       bus_rst,
  input  logic       rom_grant,
  input  logic       rx_stb,
  input  logic [7:0] rx_data,
  input  logic       tx_taken,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  logic             osc_on, sec_tick, load;
  logic [SEC_W-1:0] count, load_val;

  rtc_prescaler #(.PRESCALE_W(PRESCALE_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .run(osc_on), .tick_in(tick_32k), .sec_tick(sec_tick)
  );

  rtc_seconds i_secs (
    .clk(clk), .rst_n(rst_n), .adv(sec_tick), .load(load),
    .load_val(load_val), .count(count)
  );

  rtc_fn_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rom_grant(rom_grant),
    .rx_stb(rx_stb), .rx_data(rx_data), .tx_taken(tx_taken), .count(count),
    .tx_valid(tx_valid), .tx_data(tx_data), .osc_on(osc_on),
    .load(load), .load_val(load_val)
  );

  // R2: the one-second advance only fires on an enabled strobe
  assert_tick_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (tick_32k && osc_on));
endmodule

// File: tb/test_rtc_clock_unit.sv
module test_rtc_clock_unit;
  localparam int PW  = 4;
  localparam int PER = 1 << PW;

  logic clk = 0, rst_n = 0, tick_32k = 0, bus_rst = 0, rom_grant = 0;
  logic rx_stb = 0, tx_taken = 0;
  logic [7:0] rx_data = 0;
  logic tx_valid;
  logic [7:0] tx_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_clock_unit #(.PRESCALE_W(PW)) i_rtc_clock_unit (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_rst(bus_rst),
    .rom_grant(rom_grant), .rx_stb(rx_stb), .rx_data(rx_data),
    .tx_taken(tx_taken), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  // arithmetic model
  logic [31:0] m_sec = 0;
  int m_ph = 0;
  bit m_osc = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_32k = 1;
      @(negedge clk) tick_32k = 0;
      if (m_osc) begin
        m_ph++;
        if (m_ph == PER) begin m_ph = 0; m_sec++; end
      end
    end
  endtask

  task automatic pulse_rst();
    @(negedge clk) bus_rst = 1;
    @(negedge clk) bus_rst = 0;
  endtask

  task automatic grant();
    @(negedge clk) rom_grant = 1;
    @(negedge clk) rom_grant = 0;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk) begin rx_stb = 1; rx_data = b; end
    @(negedge clk) rx_stb = 0;
  endtask

  task automatic get(string req, output logic [7:0] b);
    @(negedge clk);
    chk(req, {31'd0, tx_valid}, 32'd1);
    b = tx_data;
    tx_taken = 1;
    @(negedge clk) tx_taken = 0;
  endtask

  task automatic read_txn(string req, output logic [7:0] c, output logic [31:0] t);
    logic [7:0] b;
    pulse_rst(); grant(); send(8'h66);
    get(req, c);
    for (int i = 0; i < 4; i++) begin get(req, b); t[8*i +: 8] = b; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] c, b;
    logic [31:0] t, t2;
    @(posedge rst_n);
    @(negedge clk);
    chk("R1 tx_valid after reset", {31'd0, tx_valid}, 0);
    read_txn("R1", c, t);
    chk("R1 ctrl after reset", c, 8'h00);
    chk("R1 time after reset", t, 0);

    // R3: oscillator off at power-up
    ticks(40);
    read_txn("R3", c, t);
    chk("R3 counter holds", t, m_sec);

    // R8/R5/R10: control only, bit3=1 bit2=0; ticks before bus reset
    pulse_rst(); grant(); send(8'h99); send(8'h08); m_osc = 1;
    ticks(40);
    read_txn("R10", c, t);
    chk("R5 ctrl bit3 wins (on)", c, 8'h0C);
    chk("R8 immediate osc and R10 no load", t, m_sec);
    chk("R2 count value", t, 32'd2);

    // R5/R3: bit3=0 bit2=1 turns off, flags F
    pulse_rst(); grant(); send(8'h99); send(8'hF4); m_osc = 0;
    ticks(50);
    read_txn("R3", c, t);
    chk("R5 ctrl bit3 wins (off) R4", c, 8'hF0);
    chk("R3 counter frozen", t, m_sec);

    // R9/R2/R6: load near wrap, prescaler phase kept
    pulse_rst(); grant(); send(8'h99); send(8'hAC);
    m_osc = 1;
    for (int i = 0; i < 4; i++) send(8'hFF);
    pulse_rst(); m_sec = 32'hFFFF_FFFF;
    ticks(PER - 1 - m_ph);
    read_txn("R9", c, t);
    chk("R4 ctrl flags A osc on", c, 8'hAC);
    chk("R9 loaded value", t, 32'hFFFF_FFFF);
    pulse_rst(); grant(); send(8'h66);
    get("R6", c);
    ticks(1);
    t = 0;
    for (int i = 0; i < 4; i++) begin get("R6", b); t[8*i +: 8] = b; end
    chk("R6 snapshot unchanged", t, 32'hFFFF_FFFF);
    chk("R2 model wrapped", m_sec, 0);
    read_txn("R2", c, t);
    chk("R2 wrap to zero", t, 0);

    // R7: cyclic repeat
    ticks(PER * 3 + 5);
    pulse_rst(); grant(); send(8'h66);
    get("R7", c); t = 0;
    for (int i = 0; i < 4; i++) begin get("R7", b); t[8*i +: 8] = b; end
    chk("R6 time LSB first", t, m_sec);
    for (int r = 0; r < 2; r++) begin
      get("R7", b); chk("R7 repeat ctrl", b, c);
      t2 = 0;
      for (int i = 0; i < 4; i++) begin get("R7", b); t2[8*i +: 8] = b; end
      chk("R7 repeat time", t2, t);
    end

    // R9: full write, ticks before reset do not survive the load
    pulse_rst(); grant(); send(8'h99); send(8'h0C);
    send(8'h78); send(8'h56); send(8'h34); send(8'h12);
    ticks(35);
    pulse_rst(); m_sec = 32'h1234_5678;
    read_txn("R9", c, t);
    chk("R9 written time", t, 32'h1234_5678);
    ticks(PER - m_ph);
    read_txn("R9", c, t);
    chk("R9 advance after load", t, 32'h1234_5679);

    // R11: ignored bytes
    pulse_rst(); send(8'h66);
    @(negedge clk); chk("R11 no access before grant", {31'd0, tx_valid}, 0);
    grant(); send(8'h55); send(8'h66);
    @(negedge clk); chk("R11 unknown command", {31'd0, tx_valid}, 0);
    send(8'h99); send(8'h00); send(8'h01);
    pulse_rst(); grant(); send(8'h66);
    get("R11", c);
    chk("R11 osc untouched by ignored bytes", c, 8'h0C);
    send(8'h99); send(8'h00);
    t = 0;
    for (int i = 0; i < 4; i++) begin get("R11", b); t[8*i +: 8] = b; end
    chk("R11 rx ignored in read", t, m_sec);
    ticks(PER);
    read_txn("R11", c, t);
    chk("R11 counter still running", t, m_sec);

    // R12: abort
    pulse_rst(); grant(); send(8'h66);
    get("R12", c); get("R12", b);
    @(negedge clk) bus_rst = 1;
    @(negedge clk) bus_rst = 0;
    chk("R12 abort", {31'd0, tx_valid}, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule